// File: doc/BRIEF.md
# DMA channel address register unit

This block holds the address state of a four-channel DMA controller. Each channel has a 16-bit base address and a 16-bit current address. The CPU reaches both through one 8-bit data path. A single byte-pointer flip-flop, shared by all channels, selects the low or high byte of each access and toggles after it. Software issues a pointer-clear command first, so that the next access lands on the low byte.

When a transfer completes, the current address of the serving channel steps up or down, as that channel's direction input selects. A transfer that ends at terminal count on a channel with auto-initialize enabled reloads the current address from the untouched base. Terminal count also sets a sticky flag in a read-only status byte, next to live copies of the request inputs. Reading the status byte clears the flags.

An 8-bit page register per channel supplies address bits 23:16. The 24-bit output address is formed for whichever channel the transfer-channel input names.

Top module: `dma_addr_unit`

## Requirements
- R1: After rst_n is low, the byte pointer selects the low byte, every terminal-count flag is 0, and all base, current and page registers are 0. With dreq at 0, the status byte is 00h.
- R2: An address write stores wdata into one byte of both base and current of channel addr_ch. The low byte (bits 7:0) is written when the pointer is 0 and the high byte (bits 15:8) when it is 1. The pointer then toggles.
- R3: ptr_clr forces the pointer to 0 for the next access, and it wins over the toggle of an access made in the same cycle.
- R4: rdata is combinationally the pointer-selected byte of current[addr_ch] (low byte when the pointer is 0). An address read toggles the pointer.
- R5: With xfer_done, current[xfer_ch] increments by 1 when dir_dn[xfer_ch]=0 and decrements by 1 when it is 1, wrapping modulo 2^16 (FFFFh+1=0000h, 0000h-1=FFFFh).
- R6: With xfer_done, tc and auto_en[xfer_ch] all high, current[xfer_ch] is reloaded from base[xfer_ch] instead of stepping. Base registers change only on address writes.
- R7: xfer_done with tc sets the terminal-count flag of xfer_ch. Status bit n (n = 0..3) holds the flag of channel n until it is cleared.
- R8: Status bits 7:4 follow dreq[3:0] combinationally (channel n at bit n+4). stat_rd clears all flags on the next edge, except a flag set by the same cycle's terminal count, which is set.
- R9: mclr clears the pointer and all terminal-count flags, and leaves the base, current and page registers unchanged.
- R10: out_addr equals {page[xfer_ch], current[xfer_ch]} combinationally. A page write stores wdata into page[pg_ch].
- R11: When an address write and a transfer hit the same channel in one cycle, the write is applied and the transfer's address change is dropped. Its terminal-count flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr | input | 1 | Master clear |
| addr_wr | input | 1 | Address byte write strobe |
| addr_rd | input | 1 | Address byte read strobe |
| addr_ch | input | 2 | Channel of the address access |
| wdata | input | 8 | Write data for address and page writes |
| rdata | output | 8 | Selected byte of the current address |
| ptr_clr | input | 1 | Byte-pointer clear command |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat | output | 8 | Request bits 7:4, terminal-count flags 3:0 |
| dreq | input | 4 | Live request per channel |
| xfer_done | input | 1 | One transfer completed |
| xfer_ch | input | 2 | Channel of the transfer |
| tc | input | 1 | Transfer reached terminal count |
| dir_dn | input | 4 | Per channel: 1 decrements, 0 increments |
| auto_en | input | 4 | Per channel auto-initialize enable |
| pg_wr | input | 1 | Page register write strobe |
| pg_ch | input | 2 | Channel of the page write |
| out_addr | output | 24 | Transfer address of xfer_ch |

## Verification
Three outputs are combinational: rdata, the request half of stat, and out_addr. The bench checks them 1 ns after it drives the inputs, in the same cycle. Register effects (byte writes, pointer toggles, steps, reloads, flag set and clear, page writes) appear on the first clock edge after the strobe. The bench updates its model at that edge and compares at the following falling edge, before it drives new inputs. No result is therefore sampled within the cycle of its own stimulus, and none is sampled near an edge.

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int PW  = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mclr,
  input  logic                addr_wr,
  input  logic                addr_rd,
  input  logic [CW-1:0]       addr_ch,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic                ptr_clr,
  input  logic                stat_rd,
  output logic [2*NCH-1:0]    stat,
  input  logic [NCH-1:0]      dreq,
  input  logic                xfer_done,
  input  logic [CW-1:0]       xfer_ch,
  input  logic                tc,
  input  logic [NCH-1:0]      dir_dn,
  input  logic [NCH-1:0]      auto_en,
  input  logic                pg_wr,
  input  logic [CW-1:0]       pg_ch,
  output logic [PW+2*DW-1:0]  out_addr
);
  localparam int AW = 2 * DW;

  logic [NCH-1:0][AW-1:0] base, cur;
  logic [NCH-1:0][PW-1:0] page;
  logic [NCH-1:0]         tcf;
  logic                   ptr;

  wire access   = addr_wr | addr_rd;
  wire wr_clash = addr_wr && (addr_ch == xfer_ch);
  wire reload   = tc && auto_en[xfer_ch];

  assign rdata    = ptr ? cur[addr_ch][AW-1:DW] : cur[addr_ch][DW-1:0];
  assign stat     = {dreq, tcf};
  assign out_addr = {page[xfer_ch], cur[xfer_ch]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ptr <= 1'b0;
    else if (mclr || ptr_clr)  ptr <= 1'b0;
    else if (access)           ptr <= ~ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcf <= '0;
    else if (mclr) tcf <= '0;
    else begin
      for (int i = 0; i < NCH; i++)
        if (xfer_done && tc && xfer_ch == CW'(i)) tcf[i] <= 1'b1;
        else if (stat_rd)                         tcf[i] <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) page <= '0;
    else if (pg_wr) page[pg_ch] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) base <= '0;
    else if (addr_wr) begin
      if (ptr) base[addr_ch][AW-1:DW] <= wdata;
      else     base[addr_ch][DW-1:0]  <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cur <= '0;
    else begin
      if (xfer_done && !wr_clash) begin
        if (reload)               cur[xfer_ch] <= base[xfer_ch];
        else if (dir_dn[xfer_ch]) cur[xfer_ch] <= cur[xfer_ch] - AW'(1);
        else                      cur[xfer_ch] <= cur[xfer_ch] + AW'(1);
      end
      if (addr_wr) begin
        if (ptr) cur[addr_ch][AW-1:DW] <= wdata;
        else     cur[addr_ch][DW-1:0]  <= wdata;
      end
    end

  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    access && !ptr_clr && !mclr |=> ptr != $past(ptr));
  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !ptr);
  p_base_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr |=> $stable(base));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && reload && !wr_clash |=> cur[$past(xfer_ch)] == $past(base[xfer_ch]));
  p_tc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && tc && !mclr |=> tcf[$past(xfer_ch)]);
  p_tc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !(xfer_done && tc) |=> tcf == '0);
  p_mclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> !ptr && tcf == '0);
  p_page_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_wr |=> $stable(page));
endmodule

// File: tb/tb_dma_addr_unit.sv
module tb_dma_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 100000;

  logic clk = 0, rst_n = 0;
  logic mclr, addr_wr, addr_rd, ptr_clr, stat_rd, xfer_done, tc, pg_wr;
  logic [1:0] addr_ch, xfer_ch, pg_ch;
  logic [7:0] wdata, rdata, stat;
  logic [3:0] dreq, dir_dn, auto_en;
  logic [23:0] out_addr;

  logic [15:0] mb [4];
  logic [15:0] mc [4];
  logic [7:0]  mp [4];
  logic [3:0]  mt;
  logic        mptr;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_unit dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sel_byte(logic [15:0] v, logic p);
    return p ? v[15:8] : v[7:0];
  endfunction

  task automatic idle();
    mclr = 0; addr_wr = 0; addr_rd = 0; ptr_clr = 0; stat_rd = 0;
    xfer_done = 0; tc = 0; pg_wr = 0;
  endtask

  task automatic model_step();
    logic [3:0] nt;
    nt = mt;
    for (int i = 0; i < 4; i++)
      if (xfer_done && tc && xfer_ch == 2'(i)) nt[i] = 1'b1;
      else if (stat_rd) nt[i] = 1'b0;
    if (mclr) nt = '0;
    if (xfer_done && !(addr_wr && addr_ch == xfer_ch)) begin
      if (tc && auto_en[xfer_ch]) mc[xfer_ch] = mb[xfer_ch];
      else if (dir_dn[xfer_ch])   mc[xfer_ch] = mc[xfer_ch] - 16'd1;
      else                        mc[xfer_ch] = mc[xfer_ch] + 16'd1;
    end
    if (addr_wr) begin
      if (mptr) begin mb[addr_ch][15:8] = wdata; mc[addr_ch][15:8] = wdata; end
      else      begin mb[addr_ch][7:0]  = wdata; mc[addr_ch][7:0]  = wdata; end
    end
    if (pg_wr) mp[pg_ch] = wdata;
    mt = nt;
    if (mclr || ptr_clr) mptr = 1'b0;
    else if (addr_wr || addr_rd) mptr = ~mptr;
  endtask

  // called just after a falling edge with inputs driven
  task automatic cyc();
    #1;
    chk("R8 status", {24'h0, stat}, {24'h0, dreq, mt});
    chk("R10 out_addr", {8'h0, out_addr}, {8'h0, mp[xfer_ch], mc[xfer_ch]});
    if (addr_rd) chk("R4 rdata", {24'h0, rdata}, {24'h0, sel_byte(mc[addr_ch], mptr)});
    model_step();
    @(negedge clk);
  endtask

  task automatic wr_addr(logic [1:0] ch, logic [15:0] v);
    idle(); ptr_clr = 1; cyc();
    idle(); addr_wr = 1; addr_ch = ch; wdata = v[7:0]; cyc();
    idle(); addr_wr = 1; addr_ch = ch; wdata = v[15:8]; cyc();
    idle();
  endtask

  task automatic xfer(logic [1:0] ch, logic t);
    idle(); xfer_done = 1; xfer_ch = ch; tc = t; cyc(); idle();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); addr_ch = 0; xfer_ch = 0; pg_ch = 0; wdata = 0;
    dreq = 0; dir_dn = 0; auto_en = 0;
    for (int i = 0; i < 4; i++) begin mb[i] = 0; mc[i] = 0; mp[i] = 0; end
    mt = 0; mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 status", {24'h0, stat}, 32'h0);
    chk("R1 out_addr", {8'h0, out_addr}, 32'h0);
    addr_rd = 1; addr_ch = 2; #1;
    chk("R1 rdata low", {24'h0, rdata}, 32'h0);
    addr_rd = 0;

    // R2 / R3 / R4: write 1234h to ch1, read back low then high
    wr_addr(2'd1, 16'h1234);
    ptr_clr = 1; cyc(); idle();
    addr_rd = 1; addr_ch = 1; #1;
    chk("R4 read low", {24'h0, rdata}, 32'h34);
    cyc(); idle(); addr_rd = 1; addr_ch = 1; #1;
    chk("R2 read high", {24'h0, rdata}, 32'h12);
    cyc(); idle();
    // R3: clear in same cycle as an access wins over toggle
    addr_rd = 1; addr_ch = 1; ptr_clr = 1; cyc(); idle();
    addr_rd = 1; addr_ch = 1; #1;
    chk("R3 clear wins", {24'h0, rdata}, 32'h34);
    cyc(); idle();

    // R5 decrement wrap and increment wrap
    wr_addr(2'd2, 16'h0000); dir_dn = 4'b0100;
    xfer(2'd2, 0); xfer_ch = 2; #1;
    chk("R5 dec wrap", {8'h0, out_addr}, 32'h00FFFF);
    wr_addr(2'd3, 16'hFFFF); dir_dn = 4'b0000;
    xfer(2'd3, 0); xfer_ch = 3; #1;
    chk("R5 inc wrap", {8'h0, out_addr}, 32'h000000);

    // R6 / R7 autoinit reload and flag
    auto_en = 4'b0010;
    xfer(2'd1, 0); xfer(2'd1, 0);
    xfer_ch = 1; #1;
    chk("R5 inc", {8'h0, out_addr}, 32'h001236);
    xfer(2'd1, 1); xfer_ch = 1; #1;
    chk("R6 reload", {8'h0, out_addr}, 32'h001234);
    chk("R7 tc flag", {24'h0, stat}, 32'h02);

    // R8: set wins over read clear; then clear
    dreq = 4'b1001;
    idle(); stat_rd = 1; xfer_done = 1; xfer_ch = 0; tc = 1; cyc(); idle(); #1;
    chk("R8 set wins", {24'h0, stat}, 32'h91);
    stat_rd = 1; cyc(); idle(); #1;
    chk("R8 cleared", {24'h0, stat}, 32'h90);

    // R10 page
    idle(); pg_wr = 1; pg_ch = 1; wdata = 8'hA5; cyc(); idle();
    xfer_ch = 1; #1;
    chk("R10 page", {8'h0, out_addr}, 32'hA51234);

    // R9 master clear
    xfer(2'd3, 1);
    idle(); addr_rd = 1; addr_ch = 1; cyc(); idle();
    mclr = 1; cyc(); idle(); #1;
    chk("R9 flags", {24'h0, stat}, 32'h90);
    addr_rd = 1; addr_ch = 1; #1;
    chk("R9 ptr low", {24'h0, rdata}, 32'h34);
    xfer_ch = 1; #1;
    chk("R9 regs kept", {8'h0, out_addr}, 32'hA51234);
    cyc(); idle();

    // R11 clash: write wins, transfer step dropped
    ptr_clr = 1; cyc(); idle();
    addr_wr = 1; addr_ch = 0; wdata = 8'h77; xfer_done = 1; xfer_ch = 0; tc = 1; cyc(); idle();
    xfer_ch = 0; #1;
    chk("R11 write wins", {16'h0, out_addr[15:0]}, {16'h0, mc[0][15:8], 8'h77});
    chk("R11 tc flag", {31'h0, stat[0]}, 32'h1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      mclr      = ($urandom % 64) == 0;
      ptr_clr   = ($urandom % 8) == 0;
      addr_wr   = ($urandom % 4) == 0;
      addr_rd   = !addr_wr && ($urandom % 3) == 0;
      addr_ch   = 2'($urandom);
      wdata     = 8'($urandom);
      stat_rd   = ($urandom % 6) == 0;
      xfer_done = ($urandom % 2) == 0;
      xfer_ch   = 2'($urandom);
      tc        = ($urandom % 5) == 0;
      pg_wr     = ($urandom % 8) == 0;
      pg_ch     = 2'($urandom);
      dreq      = 4'($urandom);
      if (n % 500 == 0) begin dir_dn = 4'($urandom); auto_en = 4'($urandom); end
      cyc();
    end
    idle(); #1;
    for (int i = 0; i < 4; i++) begin
      xfer_ch = 2'(i); #1;
      chk("R5 R6 final", {8'h0, out_addr}, {8'h0, mp[i], mc[i]});
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule